// File: doc/BRIEF.md
# Debounced 4x4 Key Matrix Scanner

This block scans a sixteen-key switch matrix wired as four rows and four columns. It drives the rows with active-low outputs, and it reads the columns, which sit high through pull-ups until a closed key joins a driven row to its column. After reset it holds every row low and waits until all columns read high, so that no key is down. It then waits for any column to fall. A low column starts a debounce wait of `DEBOUNCE_CYC` clocks. If all columns are high again when that wait ends, the event is taken as noise and dropped.

A low that survives the recheck starts a location pass. The scanner pulls one row low at a time, from row 0 to row 3. It holds each row for `SETTLE_CYC` clocks before it samples the columns, so the two-flop column synchronizer has caught up. The first row that shows a low column gives the key. The block reports it as a byte that holds the row drive pattern and the column pattern, each a nibble with exactly one zero, together with a 4-bit key number. A single-cycle valid strobe marks the report. The scanner then goes back to waiting for all keys to be released.

The result leaves as a plain strobe with no back-pressure. The consumer must capture the code in the cycle that `key_valid_o` is high. The code and number outputs keep their value until the next report.

Top module: `kpd_scan_top`

## Requirements
- R1: While reset is asserted and after it is released, all four row outputs are low and `key_valid_o` is low; a key held down through reset gives no report until every key has been released and a key is pressed again.
- R2: The row outputs are only ever all low (during release wait, idle and debounce) or have exactly one row low (during the location pass).
- R3: With all keys released, a single key held down for longer than the debounce interval plus the location pass gives exactly one report.
- R4: A column low that is gone again before the debounce interval ends gives no report, and the scanner still detects a later real press.
- R5: The location pass pulls rows low one at a time in order row 0, 1, 2, 3; each row is held for `SETTLE_CYC` (at least 3) clocks before the synchronized columns are sampled, and the reported upper nibble equals the row pattern that was driven.
- R6: `key_code_o[7:4]` has its single zero at bit 7-r for row r, and `key_code_o[3:0]` has its single zero at bit 3-c for column c; so key 0 is 0x77, key 1 is 0x7B, key 4 is 0xB7 and key 15 is 0xEE.
- R7: `key_idx_o` equals 4*row + column of the reported key.
- R8: When several keys are down, the key with the lowest number is reported: the lowest row that shows a low column, and within it the lowest column.
- R9: If the location pass finds no low column in any of the four rows, no report is made and the scanner goes back to waiting for all columns to read high.
- R10: A key that stays held down is reported once only; the next report needs all keys released first.
- R11: `key_valid_o` is high for exactly one clock per report, and `key_code_o` and `key_idx_o` change only in a cycle where `key_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_n_o | output | 4 | Active-low row drives; bit 3 is row 0 |
| col_n_i | input | 4 | Column levels, low when a key joins them to a driven row; bit 3 is column 0 |
| key_valid_o | output | 1 | One-cycle strobe marking a new report |
| key_code_o | output | 8 | Row pattern (upper nibble) and column pattern (lower nibble) of the reported key |
| key_idx_o | output | 4 | Key number, 4*row + column |

## Verification
The bench models the matrix from the driven rows and the pressed-key mask. It aims at short glitches that end before the recheck; a design that skips the recheck would report a phantom key. It holds keys down for a long time and through reset, which catches a scanner that repeats reports or does not wait for release first. It presses pairs of random keys to check the lowest-number rule, which a wrong scan order or column priority would break. It also injects a column low that is only present while all rows are driven. A scanner that does not handle the empty pass would report garbage or hang instead of going back to the release wait.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int unsigned LINES = 4;
  localparam int unsigned SEL_W = $clog2(LINES);

  typedef enum logic [1:0] {
    ST_REL  = 2'd0,
    ST_IDLE = 2'd1,
    ST_DEB  = 2'd2,
    ST_SCAN = 2'd3
  } kpd_state_e;

  // one-cold pattern: position 0 has its zero in the top bit
  function automatic logic [LINES-1:0] onecold(input logic [SEL_W-1:0] sel);
    logic [LINES-1:0] p;
    p = '1;
    p[LINES-1-sel] = 1'b0;
    return p;
  endfunction
endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= '1;
        end else begin
          if (s == 0) stg_q[s] <= d_i;
          else        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kpd_tmr.sv
module kpd_tmr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] rst_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= rst_val_i;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/kpd_col_pick.sv
module kpd_col_pick
  import kpd_pkg::*;
(
  input  logic [LINES-1:0] col_n_i,
  output logic             hit_o,
  output logic [SEL_W-1:0] col_o
);
  // lowest column number wins; column c sits at bit LINES-1-c
  always_comb begin
    hit_o = 1'b0;
    col_o = '0;
    for (int c = LINES-1; c >= 0; c--) begin
      if (!col_n_i[LINES-1-c]) begin
        hit_o = 1'b1;
        col_o = SEL_W'(c);
      end
    end
  end
endmodule

// File: rtl/kpd_ctl.sv
module kpd_ctl
  import kpd_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYC = 5000000,
  parameter int unsigned SETTLE_CYC   = 4,
  parameter int unsigned CW           = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   col_s_i,
  input  logic               hit_i,
  input  logic [SEL_W-1:0]   col_sel_i,
  input  logic               tmr_done_i,
  output logic               tmr_load_o,
  output logic [CW-1:0]      tmr_val_o,
  output logic [LINES-1:0]   row_n_o,
  output logic               valid_o,
  output logic [2*LINES-1:0] code_o,
  output logic [2*SEL_W-1:0] idx_o
);
  localparam logic [CW-1:0] DEB_LD = CW'(DEBOUNCE_CYC - 1);
  localparam logic [CW-1:0] SET_LD = CW'(SETTLE_CYC - 1);

  kpd_state_e           st_q, st_d;
  logic [SEL_W-1:0]     row_q, row_d;
  logic                 valid_d;
  logic                 all_high;

  assign all_high = (col_s_i == '1);

  always_comb begin
    st_d       = st_q;
    row_d      = row_q;
    valid_d    = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = SET_LD;
    unique case (st_q)
      ST_REL: begin
        if (tmr_done_i && all_high) st_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!all_high) begin
          st_d       = ST_DEB;
          tmr_load_o = 1'b1;
          tmr_val_o  = DEB_LD;
        end
      end
      ST_DEB: begin
        if (tmr_done_i) begin
          if (all_high) begin
            st_d = ST_IDLE;
          end else begin
            st_d       = ST_SCAN;
            row_d      = '0;
            tmr_load_o = 1'b1;
          end
        end
      end
      ST_SCAN: begin
        if (tmr_done_i) begin
          tmr_load_o = 1'b1;
          if (hit_i) begin
            valid_d = 1'b1;
            st_d    = ST_REL;
          end else if (row_q == SEL_W'(LINES-1)) begin
            st_d = ST_REL;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
      end
      default: st_d = ST_REL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_REL;
      row_q   <= '0;
      valid_o <= 1'b0;
      code_o  <= '0;
      idx_o   <= '0;
    end else begin
      st_q    <= st_d;
      row_q   <= row_d;
      valid_o <= valid_d;
      if (valid_d) begin
        code_o <= {onecold(row_q), onecold(col_sel_i)};
        idx_o  <= {row_q, col_sel_i};
      end
    end
  end

  assign row_n_o = (st_q == ST_SCAN) ? onecold(row_q) : '0;
endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top
  import kpd_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYC = 5000000,
  parameter int unsigned SETTLE_CYC   = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] row_n_o,
  input  logic [3:0] col_n_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o,
  output logic [3:0] key_idx_o
);
  localparam int unsigned MAX_LD = (DEBOUNCE_CYC > SETTLE_CYC) ? DEBOUNCE_CYC : SETTLE_CYC;
  localparam int unsigned CW     = $clog2(MAX_LD + 1);

  logic [LINES-1:0] col_s;
  logic             hit;
  logic [SEL_W-1:0] col_sel;
  logic             tmr_done, tmr_load;
  logic [CW-1:0]    tmr_val;

  initial begin
    if (SETTLE_CYC < SYNC_STAGES + 1) $error("SETTLE_CYC too small for synchronizer depth");
    if (DEBOUNCE_CYC < 1) $error("DEBOUNCE_CYC must be nonzero");
  end

  kpd_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (col_n_i),
    .q_o   (col_s)
  );

  kpd_col_pick u_pick (
    .col_n_i (col_s),
    .hit_o   (hit),
    .col_o   (col_sel)
  );

  kpd_tmr #(.CW(CW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .rst_val_i  (CW'(SETTLE_CYC - 1)),
    .done_o     (tmr_done)
  );

  kpd_ctl #(.DEBOUNCE_CYC(DEBOUNCE_CYC), .SETTLE_CYC(SETTLE_CYC), .CW(CW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .col_s_i    (col_s),
    .hit_i      (hit),
    .col_sel_i  (col_sel),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .row_n_o    (row_n_o),
    .valid_o    (key_valid_o),
    .code_o     (key_code_o),
    .idx_o      (key_idx_o)
  );
endmodule

// File: rtl/kpd_scan_chk.sv
module kpd_scan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] row_n_o,
  input logic       key_valid_o,
  input logic [7:0] key_code_o,
  input logic [3:0] key_idx_o
);
  assert_row_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_n_o == 4'h0) || ($countones(row_n_o) == 3));

  assert_code_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |-> ($countones(key_code_o[7:4]) == 3) && ($countones(key_code_o[3:0]) == 3));

  assert_idx_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |-> (key_code_o[7 - key_idx_o[3:2]] == 1'b0) && (key_code_o[3 - key_idx_o[1:0]] == 1'b0));

  assert_row_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |-> ($past(row_n_o) == key_code_o[7:4]));

  assert_back_to_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |-> (row_n_o == 4'h0));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |=> !key_valid_o);

  assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid_o |-> ($stable(key_code_o) && $stable(key_idx_o)));
endmodule

bind kpd_scan_top kpd_scan_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .row_n_o     (row_n_o),
  .key_valid_o (key_valid_o),
  .key_code_o  (key_code_o),
  .key_idx_o   (key_idx_o)
);

// File: tb/kpd_scan_top_tb_top.sv
module kpd_scan_top_tb_top;
  localparam int DEB = 40;
  localparam int SET = 4;
  localparam int PRESS_WAIT = DEB + 4*SET + 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] row_n;
  logic [3:0] col_n;
  logic       key_valid;
  logic [7:0] key_code;
  logic [3:0] key_idx;

  logic [15:0] pressed = '0;
  logic        ghost = 1'b0;
  int checks = 0;
  int failures = 0;
  int vcount = 0;
  int row_bad = 0;
  logic [7:0] last_code = '0;
  logic [3:0] last_idx = '0;

  always #2 clk = ~clk;

  kpd_scan_top #(.DEBOUNCE_CYC(DEB), .SETTLE_CYC(SET)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_n_o     (row_n),
    .col_n_i     (col_n),
    .key_valid_o (key_valid),
    .key_code_o  (key_code),
    .key_idx_o   (key_idx)
  );

  // matrix model: key 4r+c joins row r (bit 3-r) to column c (bit 3-c)
  always_comb begin
    col_n = 4'hF;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (pressed[4*r+c] && !row_n[3-r]) col_n[3-c] = 1'b0;
    if (ghost && row_n == 4'h0) col_n[1] = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (key_valid) begin
        vcount    <= vcount + 1;
        last_code <= key_code;
        last_idx  <= key_idx;
      end
      if (!(row_n == 4'h0 || $countones(row_n) == 3)) row_bad <= row_bad + 1;
    end
  end

  function automatic logic [7:0] exp_code(input logic [3:0] k);
    logic [3:0] hi, lo;
    hi = 4'hF; lo = 4'hF;
    hi[3 - k[3:2]] = 1'b0;
    lo[3 - k[1:0]] = 1'b0;
    return {hi, lo};
  endfunction

  function automatic logic [3:0] exp_first(input logic [15:0] m);
    logic [3:0] f;
    f = 4'd0;
    for (int i = 15; i >= 0; i--) if (m[i]) f = 4'(i);
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press_check(input logic [15:0] m, input string req);
    int base;
    logic [3:0] k;
    base = vcount;
    k = exp_first(m);
    pressed = m;
    wait_clk(PRESS_WAIT);
    chk(vcount == base + 1, req, vcount - base, 1);
    chk(last_code == exp_code(k), {req, " R6 code"}, last_code, exp_code(k));
    chk(last_idx == k, {req, " R7 idx"}, last_idx, k);
    pressed = '0;
    wait_clk(3*SET + 10);
  endtask

  initial begin
    int base;
    process::self().srandom(32'h5EED_0042);
    wait_clk(5);
    // R1: reset state
    chk(row_n == 4'h0, "R1 rows in reset", row_n, 0);
    chk(key_valid == 1'b0, "R1 valid in reset", key_valid, 0);
    rst_n = 1'b1;
    wait_clk(3);
    chk(row_n == 4'h0 && key_code == 8'h00 && key_idx == 4'h0, "R1 after reset", {row_n, key_code}, 0);

    // R3 R6 R7: every key once
    for (int k = 0; k < 16; k++) press_check(16'(1) << k, "R3 single key");

    // R4: short glitch rejected
    base = vcount;
    pressed = 16'h0020;
    wait_clk(DEB/2);
    pressed = '0;
    wait_clk(3*DEB);
    chk(vcount == base, "R4 glitch ignored", vcount - base, 0);
    press_check(16'h0400, "R4 later press");

    // R10: held key reported once
    base = vcount;
    pressed = 16'h0100;
    wait_clk(6*DEB);
    chk(vcount == base + 1, "R10 held key once", vcount - base, 1);
    pressed = '0;
    wait_clk(3*SET + 10);

    // R1: key held through reset
    pressed = 16'h8000;
    wait_clk(3);
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    base = vcount;
    wait_clk(4*DEB);
    chk(vcount == base, "R1 held through reset", vcount - base, 0);
    pressed = '0;
    wait_clk(3*SET + 10);
    press_check(16'h0002, "R1 press after reset release");

    // R9: column low that no single row reproduces
    base = vcount;
    ghost = 1'b1;
    wait_clk(4*DEB);
    chk(vcount == base, "R9 empty pass no report", vcount - base, 0);
    chk(row_n == 4'h0, "R9 back to release wait", row_n, 0);
    ghost = 1'b0;
    wait_clk(3*SET + 10);
    press_check(16'h0200, "R9 recovers");

    // R3 random single keys
    for (int i = 0; i < 12; i++) press_check(16'(1) << ($urandom % 16), "R3 random key");

    // R8: random pairs, lowest number wins
    for (int i = 0; i < 12; i++) begin
      logic [3:0] a, b;
      a = 4'($urandom % 16);
      b = 4'($urandom % 16);
      press_check((16'(1) << a) | (16'(1) << b), "R8 pair priority");
    end
    press_check(16'h8001, "R8 corner keys 0 and 15");
    press_check(16'h8888, "R8 one column all rows");

    // R2: row legality observed throughout
    chk(row_bad == 0, "R2 row pattern legal", row_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule